// File: doc/BRIEF.md
# External Bus Cycle Controller

This block sits between a processor core and the external pins of a chip. It turns each core read or write into one or two fixed-length external bus cycles. Every bus cycle lasts four bus states (T1 to T4). Internally, each state is two ticks of the block clock `clk`, so the first half and the second half of a state can differ. The address is presented twice. It appears first on a dedicated address output at the start of T1. It appears again, one tick (half a state) later, on the shared address/data lines. Those shared lines then carry write data, or float while read data is sampled.

The data width, 8 or 16 bits, is set separately for memory space and for I/O space. The width is sampled only when a request is accepted. A 16-bit access becomes two back-to-back byte cycles when it targets an 8-bit region or an odd address. Separate active-low write enables select the high byte lane and the low byte lane. An address-off mode keeps the address off the shared lines altogether.

A build-time option gives a fixed 8-bit build. In that build, address bits 15..8 are held on their own outputs for the whole cycle. A chip-select input vector is passed to the pins only while a cycle is in progress.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: After reset and whenever no cycle is running, the outputs are at rest: `rd_n`, `wr_n`, `we_hi_n` and `we_lo_n` are 1, `ad_oe_lo` and `ad_oe_hi` are 0, `ack` is 0, `addr_out` is 0 and `cs_n_out` is all ones.
- R2: A bus cycle is eight ticks: T1a, T1b, T2a, T2b, T3a, T3b, T4a, T4b. Tick T1a starts on the tick after the request is sampled in the idle state. `addr_out` holds the cycle address for all eight ticks. The tick after the final T4b is always idle, and a new request is sampled there.
- R3: Unless address-off mode is active, the shared lines carry address bits 15..0 during T1b only, one tick after `addr_out`. In the standard build both lane enables are set; in the fixed 8-bit build only the low lane enable is set.
- R4: `rd_n` is low from T1b through T3b of a read. `wr_n` is low over the same ticks of a write. The two are never low together.
- R5: During a read cycle the shared lines are never driven after T1b. Read data on `ad_in` is captured at the clock edge that ends T3b. A byte read returns its byte in `rdata[7:0]`, with `rdata[15:8]` = 0.
- R6: During a write, the data is driven from T2a through T4b. A 16-bit cycle drives both lanes. A byte cycle drives only the lane that carries that byte.
- R7: Write enables are low only from T1b through T3b of a write cycle. Both are low for a 16-bit cycle. A byte cycle on a 16-bit region lowers `we_hi_n` if address bit 0 is 1, and `we_lo_n` if it is 0. Every byte cycle on an 8-bit region uses the low lane and `we_lo_n`.
- R8: The width for memory (`cfg_mem16`, 1 = 16-bit) or for I/O (`cfg_io16`), chosen by `req_io`, is sampled together with `cfg_mux_noaddr` when the request is accepted. Later changes to these inputs do not affect cycles already under way.
- R9: A 16-bit access to an 8-bit region runs as two byte cycles with no gap between them. The first carries the low byte at `req_addr`. The second carries the high byte at `req_addr`+1, wrapping within the address width.
- R10: A 16-bit access at an odd address on a 16-bit region is also split in the same order. The first byte uses the high lane and the second byte uses the low lane.
- R11: `ack` is high for exactly one tick, during T4b of the last cycle of a request. A read's full result is on `rdata` in that tick: `{byte at addr+1, byte at addr}` for a 16-bit access.
- R12: With address-off mode sampled as 1, the shared lines are never driven during T1. Only write data is driven, from T2a.
- R13: In the fixed 8-bit build (`NARROW_BUS`=1), every access is treated as 8-bit. `addr_hi_out` holds the cycle's address bits 15..8 for all eight ticks, and the high lane is never driven or enabled. In the standard build `addr_hi_out` is 0.
- R14: `cs_n_out` follows `cs_n_in` during every tick of a cycle and is all ones otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one tick is half a bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Core request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 16 | Write data; a byte write uses bits 7..0 |
| ack | output | 1 | One-tick completion pulse |
| rdata | output | 16 | Assembled read result |
| cfg_mem16 | input | 1 | Memory space is 16 bits wide |
| cfg_io16 | input | 1 | I/O space is 16 bits wide |
| cfg_mux_noaddr | input | 1 | Address-off mode for the shared lines |
| cs_n_in | input | CS_W | Chip selects from the external decoder |
| cs_n_out | output | CS_W | Chip selects gated to the cycle |
| addr_out | output | ADDR_W | Dedicated address bus |
| addr_hi_out | output | 8 | Held address bits 15..8 (fixed 8-bit build) |
| ad_out | output | 16 | Shared address/data lines, output value |
| ad_oe_lo | output | 1 | Drive enable for shared lines 7..0 |
| ad_oe_hi | output | 1 | Drive enable for shared lines 15..8 |
| ad_in | input | 16 | Shared address/data lines, pin value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| we_hi_n | output | 1 | High byte write enable, active low |
| we_lo_n | output | 1 | Low byte write enable, active low |

## Verification
Some rules must hold on every tick, whatever the traffic, so the assertions check them continuously. These are: the read and write strobes are never low together, the pins are quiet in idle, the shared lines float during reads, `addr_out` stays stable inside a cycle, `ack` is a single pulse followed by an idle tick, and the shared lines stay undriven in T1 under address-off mode. Other behaviour depends on the values a request carries, and only the bench's scenarios can show it. That includes the exact lane chosen for each byte, the order and addresses of split halves (including wrap at the top of the address range), the assembly of read bytes into `rdata`, and the fact that a width change made mid-cycle is ignored.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

  localparam int XBC_DW = 16;
  localparam int XBC_BW = 8;

  typedef enum logic [2:0] {
    PH_T1A = 3'd0, PH_T1B = 3'd1, PH_T2A = 3'd2, PH_T2B = 3'd3,
    PH_T3A = 3'd4, PH_T3B = 3'd5, PH_T4A = 3'd6, PH_T4B = 3'd7
  } xbc_ph_e;

  typedef struct packed {
    logic we;
    logic word;
    logic bus16;
    logic noaddr;
    logic split;
  } xbc_flags_t;

  // A word access needs two byte cycles on a narrow region or when misaligned.
  function automatic logic xbc_split(input logic word, input logic bus16, input logic a0);
    return word && (!bus16 || a0);
  endfunction

  // A single byte rides the high lane only on a 16-bit region at an odd address.
  function automatic logic xbc_hi_lane(input logic bus16, input logic a0);
    return bus16 && a0;
  endfunction

  // Byte carried by a byte cycle: low half first, high half on the second cycle.
  function automatic logic [XBC_BW-1:0] xbc_pick_byte(input logic second,
                                                      input logic [XBC_DW-1:0] data);
    return second ? data[XBC_DW-1:XBC_BW] : data[XBC_BW-1:0];
  endfunction

  function automatic logic [XBC_BW-1:0] xbc_lane_byte(input logic hi,
                                                      input logic [XBC_DW-1:0] pins);
    return hi ? pins[XBC_DW-1:XBC_BW] : pins[XBC_BW-1:0];
  endfunction

endpackage

// File: rtl/xbc_seq.sv
module xbc_seq
  import xbc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter bit NARROW_BUS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_io,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XBC_DW-1:0] req_wdata,
  input  logic              cfg_mem16,
  input  logic              cfg_io16,
  input  logic              cfg_mux_noaddr,
  output logic              busy,
  output xbc_ph_e           ph,
  output logic              second,
  output xbc_flags_t        flags,
  output logic [ADDR_W-1:0] base_addr,
  output logic [XBC_DW-1:0] wdata_q,
  output logic              cap_evt,
  output logic              ack
);

  logic bus16_next;
  logic last_cyc;
  logic end_cyc;

  always_comb begin
    bus16_next = !NARROW_BUS && (req_io ? cfg_io16 : cfg_mem16);
    last_cyc   = !flags.split || second;
    end_cyc    = busy && (ph == PH_T4B);
    ack        = end_cyc && last_cyc;
    cap_evt    = busy && (ph == PH_T3B) && !flags.we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ph        <= PH_T1A;
      second    <= 1'b0;
      flags     <= '0;
      base_addr <= '0;
      wdata_q   <= '0;
    end else if (!busy) begin
      if (req) begin
        busy         <= 1'b1;
        ph           <= PH_T1A;
        second       <= 1'b0;
        flags.we     <= req_we;
        flags.word   <= req_word;
        flags.bus16  <= bus16_next;
        flags.noaddr <= cfg_mux_noaddr;
        flags.split  <= xbc_split(req_word, bus16_next, req_addr[0]);
        base_addr    <= req_addr;
        wdata_q      <= req_wdata;
      end
    end else if (end_cyc) begin
      ph <= PH_T1A;
      if (last_cyc) begin
        busy <= 1'b0;
      end else begin
        second <= 1'b1;
      end
    end else begin
      ph <= xbc_ph_e'(ph + 3'd1);
    end
  end

endmodule

// File: rtl/xbc_lane.sv
module xbc_lane
  import xbc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter bit NARROW_BUS = 1'b0
) (
  input  logic              busy,
  input  xbc_ph_e           ph,
  input  logic              second,
  input  xbc_flags_t        flags,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [XBC_DW-1:0] wdata_q,
  output logic              full_word,
  output logic              hi_lane,
  output logic [ADDR_W-1:0] addr_out,
  output logic [XBC_BW-1:0] addr_hi_out,
  output logic [XBC_DW-1:0] ad_out,
  output logic              ad_oe_lo,
  output logic              ad_oe_hi,
  output logic              rd_n,
  output logic              wr_n,
  output logic              we_hi_n,
  output logic              we_lo_n
);

  logic [ADDR_W-1:0] cur_addr;
  logic [XBC_BW-1:0] bval;
  logic              strobe_win;
  logic              addr_ph;
  logic              data_ph;

  always_comb begin
    cur_addr   = base_addr + ADDR_W'(second);
    full_word  = flags.word && !flags.split;
    hi_lane    = xbc_hi_lane(flags.bus16, cur_addr[0]);
    bval       = xbc_pick_byte(second, wdata_q);
    strobe_win = busy && (ph >= PH_T1B) && (ph <= PH_T3B);
    addr_ph    = busy && (ph == PH_T1B) && !flags.noaddr;
    data_ph    = busy && flags.we && (ph >= PH_T2A);

    ad_out   = '0;
    ad_oe_lo = 1'b0;
    ad_oe_hi = 1'b0;
    if (addr_ph) begin
      ad_out   = cur_addr[XBC_DW-1:0];
      ad_oe_lo = 1'b1;
      ad_oe_hi = !NARROW_BUS;
    end else if (data_ph) begin
      if (full_word) begin
        ad_out   = wdata_q;
        ad_oe_lo = 1'b1;
        ad_oe_hi = 1'b1;
      end else begin
        ad_out   = {bval, bval};
        ad_oe_lo = !hi_lane;
        ad_oe_hi = hi_lane;
      end
    end

    rd_n    = !(strobe_win && !flags.we);
    wr_n    = !(strobe_win && flags.we);
    we_hi_n = !(strobe_win && flags.we && (full_word || hi_lane));
    we_lo_n = !(strobe_win && flags.we && (full_word || !hi_lane));

    addr_out    = busy ? cur_addr : '0;
    addr_hi_out = (NARROW_BUS && busy) ? cur_addr[XBC_DW-1:XBC_BW] : '0;
  end

endmodule

// File: rtl/xbc_rdcap.sv
module xbc_rdcap
  import xbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic              second,
  input  logic              full_word,
  input  logic              hi_lane,
  input  logic [XBC_DW-1:0] ad_in,
  output logic [XBC_DW-1:0] rdata
);

  logic [XBC_BW-1:0] lane_val;

  always_comb lane_val = xbc_lane_byte(hi_lane, ad_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_evt) begin
      if (full_word) begin
        rdata <= ad_in;
      end else if (second) begin
        rdata[XBC_DW-1:XBC_BW] <= lane_val;
      end else begin
        rdata <= {{XBC_BW{1'b0}}, lane_val};
      end
    end
  end

endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int CS_W       = 2,
  parameter bit NARROW_BUS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_io,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              ack,
  output logic [15:0]       rdata,
  input  logic              cfg_mem16,
  input  logic              cfg_io16,
  input  logic              cfg_mux_noaddr,
  input  logic [CS_W-1:0]   cs_n_in,
  output logic [CS_W-1:0]   cs_n_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic [7:0]        addr_hi_out,
  output logic [15:0]       ad_out,
  output logic              ad_oe_lo,
  output logic              ad_oe_hi,
  input  logic [15:0]       ad_in,
  output logic              rd_n,
  output logic              wr_n,
  output logic              we_hi_n,
  output logic              we_lo_n
);

  // Named internal events, brought out for the bound checker.
  logic              cyc_busy;
  xbc_ph_e           cyc_ph_e;
  logic [2:0]        cyc_ph;
  logic              cyc_second;
  logic              cyc_we;
  logic              cyc_noaddr;
  logic              cap_evt;
  logic              full_word;
  logic              hi_lane;
  xbc_flags_t        flags;
  logic [ADDR_W-1:0] base_addr;
  logic [XBC_DW-1:0] wdata_q;

  xbc_seq #(.ADDR_W(ADDR_W), .NARROW_BUS(NARROW_BUS)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req            (req),
    .req_we         (req_we),
    .req_io         (req_io),
    .req_word       (req_word),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .cfg_mem16      (cfg_mem16),
    .cfg_io16       (cfg_io16),
    .cfg_mux_noaddr (cfg_mux_noaddr),
    .busy           (cyc_busy),
    .ph             (cyc_ph_e),
    .second         (cyc_second),
    .flags          (flags),
    .base_addr      (base_addr),
    .wdata_q        (wdata_q),
    .cap_evt        (cap_evt),
    .ack            (ack)
  );

  xbc_lane #(.ADDR_W(ADDR_W), .NARROW_BUS(NARROW_BUS)) u_lane (
    .busy        (cyc_busy),
    .ph          (cyc_ph_e),
    .second      (cyc_second),
    .flags       (flags),
    .base_addr   (base_addr),
    .wdata_q     (wdata_q),
    .full_word   (full_word),
    .hi_lane     (hi_lane),
    .addr_out    (addr_out),
    .addr_hi_out (addr_hi_out),
    .ad_out      (ad_out),
    .ad_oe_lo    (ad_oe_lo),
    .ad_oe_hi    (ad_oe_hi),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .we_hi_n     (we_hi_n),
    .we_lo_n     (we_lo_n)
  );

  xbc_rdcap u_rdcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_evt   (cap_evt),
    .second    (cyc_second),
    .full_word (full_word),
    .hi_lane   (hi_lane),
    .ad_in     (ad_in),
    .rdata     (rdata)
  );

  always_comb begin
    cyc_ph     = cyc_ph_e;
    cyc_we     = flags.we;
    cyc_noaddr = flags.noaddr;
    cs_n_out   = cyc_busy ? cs_n_in : '1;
  end

endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
  parameter int ADDR_W     = 20,
  parameter int CS_W       = 2,
  parameter bit NARROW_BUS = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_busy,
  input logic [2:0]        cyc_ph,
  input logic              cyc_we,
  input logic              cyc_noaddr,
  input logic              ack,
  input logic              rd_n,
  input logic              wr_n,
  input logic              we_hi_n,
  input logic              we_lo_n,
  input logic              ad_oe_lo,
  input logic              ad_oe_hi,
  input logic [ADDR_W-1:0] addr_out,
  input logic [CS_W-1:0]   cs_n_out
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_busy |-> (rd_n && wr_n && we_hi_n && we_lo_n && !ad_oe_lo && !ad_oe_hi
                   && !ack && (cs_n_out == '1))); // R1

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && cyc_ph != 3'd0) |-> $stable(addr_out)); // R2

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R11

  AST_IDLE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !cyc_busy); // R2

  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && !cyc_we && cyc_ph != 3'd1) |-> (!ad_oe_lo && !ad_oe_hi)); // R5

  AST_NOADDR_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && cyc_noaddr && cyc_ph <= 3'd1) |-> (!ad_oe_lo && !ad_oe_hi)); // R12

  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_hi_n || !we_lo_n) |-> !wr_n); // R7

  generate
    if (NARROW_BUS) begin : g_narrow
      AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ad_oe_hi && we_hi_n)); // R13
    end
  endgenerate

endmodule

bind xbus_cycle_ctrl xbc_checker #(
  .ADDR_W(ADDR_W), .CS_W(CS_W), .NARROW_BUS(NARROW_BUS)
) u_xbc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_busy   (cyc_busy),
  .cyc_ph     (cyc_ph),
  .cyc_we     (cyc_we),
  .cyc_noaddr (cyc_noaddr),
  .ack        (ack),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .we_hi_n    (we_hi_n),
  .we_lo_n    (we_lo_n),
  .ad_oe_lo   (ad_oe_lo),
  .ad_oe_hi   (ad_oe_hi),
  .addr_out   (addr_out),
  .cs_n_out   (cs_n_out)
);

// File: tb/xbus_cycle_ctrl_test.sv
module xbus_cycle_ctrl_test;

  localparam int AW = 20;
  localparam int CW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          req, we, io, word;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic          mem16, io16, noaddr;
  logic [CW-1:0] cs_in;
  logic          sel8;
  logic          exp_bus16;
  logic [15:0]   ad_in;

  logic          a_ack, b_ack;
  logic [15:0]   a_rdata, b_rdata, a_ad, b_ad;
  logic [CW-1:0] a_cs, b_cs;
  logic [AW-1:0] a_addr, b_addr;
  logic [7:0]    a_hi, b_hi;
  logic          a_oel, a_oeh, b_oel, b_oeh;
  logic          a_rd, a_wr, a_weh, a_wel, b_rd, b_wr, b_weh, b_wel;

  int n_cmp = 0;
  int n_bad = 0;

  xbus_cycle_ctrl #(.ADDR_W(AW), .CS_W(CW), .NARROW_BUS(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req(req && !sel8), .req_we(we), .req_io(io),
    .req_word(word), .req_addr(addr), .req_wdata(wdata), .ack(a_ack), .rdata(a_rdata),
    .cfg_mem16(mem16), .cfg_io16(io16), .cfg_mux_noaddr(noaddr), .cs_n_in(cs_in),
    .cs_n_out(a_cs), .addr_out(a_addr), .addr_hi_out(a_hi), .ad_out(a_ad),
    .ad_oe_lo(a_oel), .ad_oe_hi(a_oeh), .ad_in(ad_in), .rd_n(a_rd), .wr_n(a_wr),
    .we_hi_n(a_weh), .we_lo_n(a_wel)
  );

  xbus_cycle_ctrl #(.ADDR_W(AW), .CS_W(CW), .NARROW_BUS(1'b1)) uut8 (
    .clk(clk), .rst_n(rst_n), .req(req && sel8), .req_we(we), .req_io(io),
    .req_word(word), .req_addr(addr), .req_wdata(wdata), .ack(b_ack), .rdata(b_rdata),
    .cfg_mem16(mem16), .cfg_io16(io16), .cfg_mux_noaddr(noaddr), .cs_n_in(cs_in),
    .cs_n_out(b_cs), .addr_out(b_addr), .addr_hi_out(b_hi), .ad_out(b_ad),
    .ad_oe_lo(b_oel), .ad_oe_hi(b_oeh), .ad_in(ad_in), .rd_n(b_rd), .wr_n(b_wr),
    .we_hi_n(b_weh), .we_lo_n(b_wel)
  );

  // Observed pins of whichever instance the current transaction targets.
  wire          o_ack   = sel8 ? b_ack   : a_ack;
  wire [15:0]   o_rdata = sel8 ? b_rdata : a_rdata;
  wire [15:0]   o_ad    = sel8 ? b_ad    : a_ad;
  wire [CW-1:0] o_cs    = sel8 ? b_cs    : a_cs;
  wire [AW-1:0] o_addr  = sel8 ? b_addr  : a_addr;
  wire [7:0]    o_hi    = sel8 ? b_hi    : a_hi;
  wire          o_oel   = sel8 ? b_oel   : a_oel;
  wire          o_oeh   = sel8 ? b_oeh   : a_oeh;
  wire          o_rd    = sel8 ? b_rd    : a_rd;
  wire          o_wr    = sel8 ? b_wr    : a_wr;
  wire          o_weh   = sel8 ? b_weh   : a_weh;
  wire          o_wel   = sel8 ? b_wel   : a_wel;

  // Content of the external memory at a byte address.
  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'hA5;
  endfunction

  // Responder: 16-bit regions present the even byte low, odd byte high.
  always_comb begin
    if (exp_bus16) ad_in = {mb(o_addr | AW'(1)), mb(o_addr & ~AW'(1))};
    else           ad_in = {8'h00, mb(o_addr)};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " rd_n"}, 32'(o_rd), 32'd1);
    chk({tag, " wr_n"}, 32'(o_wr), 32'd1);
    chk({tag, " we_n"}, {30'd0, o_weh, o_wel}, 32'd3);
    chk({tag, " oe"}, {30'd0, o_oeh, o_oel}, 32'd0);
    chk({tag, " ack"}, 32'(o_ack), 32'd0);
    chk({tag, " addr"}, 32'(o_addr), 32'd0);
    chk({tag, " cs"}, 32'(o_cs), 32'(2**CW - 1));
  endtask

  // One request, checked tick by tick; entered and left on a falling edge in idle.
  task automatic run_txn(input logic t_we, input logic t_io, input logic t_word,
                         input logic [AW-1:0] t_addr, input logic [15:0] t_wd,
                         input logic t_m16, input logic t_i16, input logic t_na,
                         input logic [CW-1:0] t_cs, input logic t_sel8);
    logic b16, split, full, hl, last, win, elo, ehi;
    logic [AW-1:0] ac;
    logic [7:0] bv;
    logic [15:0] ead, erd;
    int ncyc;
    string tg;
    sel8 = t_sel8;
    chk_idle("R1 idle");
    we = t_we; io = t_io; word = t_word; addr = t_addr; wdata = t_wd;
    mem16 = t_m16; io16 = t_i16; noaddr = t_na; cs_in = t_cs;
    b16   = !t_sel8 && (t_io ? t_i16 : t_m16);
    exp_bus16 = b16;
    split = t_word && (!b16 || t_addr[0]);
    full  = t_word && !split;
    ncyc  = split ? 2 : 1;
    erd   = t_word ? {mb(t_addr + AW'(1)), mb(t_addr)} : {8'h00, mb(t_addr)};
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < ncyc; c++) begin
      for (int k = 0; k < 8; k++) begin
        ac   = t_addr + AW'(c);
        hl   = b16 && ac[0];
        bv   = (c == 1) ? t_wd[15:8] : t_wd[7:0];
        last = (c == ncyc - 1);
        win  = (k >= 1) && (k <= 5);
        chk("R2 addr_out", 32'(o_addr), 32'(ac));
        chk("R13 addr_hi_out", 32'(o_hi), t_sel8 ? 32'(ac[15:8]) : 32'd0);
        chk("R14 cs_n_out", 32'(o_cs), 32'(t_cs));
        chk("R4 rd_n", 32'(o_rd), 32'(!(win && !t_we)));
        chk("R4 wr_n", 32'(o_wr), 32'(!(win && t_we)));
        chk("R7 R8 we_hi_n", 32'(o_weh), 32'(!(win && t_we && (full || hl))));
        chk("R7 R8 we_lo_n", 32'(o_wel), 32'(!(win && t_we && (full || !hl))));
        elo = 1'b0; ehi = 1'b0; ead = '0;
        if (k == 1 && !t_na) begin
          elo = 1'b1; ehi = !t_sel8; ead = ac[15:0];
        end else if (k >= 2 && t_we) begin
          if (full) begin elo = 1'b1; ehi = 1'b1; ead = t_wd; end
          else begin elo = !hl; ehi = hl; ead = {bv, bv}; end
        end
        if (k <= 1) tg = t_na ? "R12 shared lines" : "R3 shared lines";
        else        tg = t_we ? "R6 R8 shared lines" : "R5 shared lines";
        chk({tg, " oe_lo"}, 32'(o_oel), 32'(elo));
        chk({tg, " oe_hi"}, 32'(o_oeh), 32'(ehi));
        if (elo) chk({tg, " low lane"}, 32'(o_ad[7:0]), 32'(ead[7:0]));
        if (ehi) chk({tg, " high lane"}, 32'(o_ad[15:8]), 32'(ead[15:8]));
        chk("R11 ack", 32'(o_ack), 32'(k == 7 && last));
        if (k == 7 && last && !t_we) begin
          if (split) chk(b16 ? "R10 rdata" : "R9 rdata", 32'(o_rdata), 32'(erd));
          else       chk("R5 R11 rdata", 32'(o_rdata), 32'(erd));
        end
        if (k == 2) begin
          // R8: width and mode inputs change mid-cycle and must be ignored
          mem16  = $urandom_range(0, 1);
          io16   = $urandom_range(0, 1);
          noaddr = $urandom_range(0, 1);
        end
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h2468ACE1));
    rst_n = 1'b0; req = 1'b0; we = 1'b0; io = 1'b0; word = 1'b0;
    addr = '0; wdata = '0; mem16 = 1'b1; io16 = 1'b1; noaddr = 1'b0;
    cs_in = '1; sel8 = 1'b0; exp_bus16 = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 reset");
    sel8 = 1'b1;
    chk_idle("R1 reset narrow");
    sel8 = 1'b0;

    // Directed corner cases
    run_txn(1, 0, 1, 20'h01234, 16'hBEEF, 1, 1, 0, 2'b10, 0); // aligned word write
    run_txn(0, 0, 1, 20'h05678, 16'h0000, 1, 1, 0, 2'b01, 0); // aligned word read
    run_txn(1, 0, 1, 20'h0A000, 16'hC3A5, 0, 1, 0, 2'b10, 0); // R9 split write
    run_txn(0, 1, 1, 20'h00302, 16'h0000, 1, 0, 0, 2'b00, 0); // R9 split read, I/O 8-bit
    run_txn(0, 0, 1, 20'h12345, 16'h0000, 1, 1, 0, 2'b01, 0); // R10 odd word read
    run_txn(1, 0, 1, 20'h12345, 16'h5AA5, 1, 1, 0, 2'b01, 0); // R10 odd word write
    run_txn(1, 0, 0, 20'h00011, 16'h0077, 1, 1, 0, 2'b10, 0); // R7 high-lane byte
    run_txn(1, 0, 0, 20'h00010, 16'h0066, 1, 1, 0, 2'b10, 0); // R7 low-lane byte
    run_txn(0, 0, 1, 20'hFFFFF, 16'h0000, 1, 1, 0, 2'b01, 0); // wrap to 0
    run_txn(0, 0, 1, 20'h04000, 16'h0000, 1, 1, 1, 2'b01, 0); // R12 read
    run_txn(1, 0, 0, 20'h04001, 16'h0012, 0, 1, 1, 2'b01, 0); // R12 write
    run_txn(1, 1, 1, 20'h00200, 16'h9876, 0, 1, 0, 2'b00, 0); // I/O 16 with mem 8
    run_txn(1, 0, 1, 20'h3C0DE, 16'h4321, 1, 1, 0, 2'b01, 1); // R13 narrow write
    run_txn(0, 0, 1, 20'h2AB00, 16'h0000, 1, 1, 0, 2'b10, 1); // R13 narrow read

    // Constrained random traffic
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom);
      if ($urandom_range(0, 9) == 0) ra = '1;
      run_txn(1'($urandom), 1'($urandom), 1'($urandom), ra, 16'($urandom),
              1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
              CW'($urandom), ($urandom_range(0, 4) == 0));
    end

    req = 1'b0;
    @(negedge clk);
    chk_idle("R1 final");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule